// File: doc/BRIEF.md
# Parallel Word Capture Engine

This block records a burst of 16-bit words, one per clock, into an external asynchronous static RAM. The word source is a valid/ready stream. While a capture is running, `in_ready` stays high and every cycle with `in_valid` high produces exactly one RAM write. The block never applies back-pressure during a capture, so a source that presents a word on every cycle loses none. When no capture is running, `in_ready` is low and any word offered is not taken. The input word passes through one front register and then one output register. The RAM sees address, data, write enable and chip select straight from flops, held for one full clock per word.

Software prepares a capture through a small bank of byte-wide registers on a 5-bit address. It sets a word count, a start source, a start delay and an address mode, and then arms the engine. An armed engine starts on a rising edge of the external trigger, or after a programmed number of cycles when the internal timer is selected. The capture runs until the programmed number of words has been taken. In stop mode it also ends when the top RAM location has been written. Busy and done are visible on pins and in a status register.

Top module: `pcap_sram_top`

## Requirements
- R1: Reset state. Directly after reset: `sram_we_n` and `sram_ce_n` are 1, `in_ready`, `cap_busy` and `cap_done` are 0, and the status register reads 0.
- R2: Register map on the 5-bit address.
  - 0x00 control: bit0 arm (reads back as the armed flag), bit1 start source (1 = timer, 0 = trigger), bit2 address mode (1 = wrap, 0 = stop).
  - 0x01 and 0x02: word count, low byte and high byte.
  - 0x03 and 0x04: start delay, low byte and high byte.
  - 0x10 status: bit0 busy, bit1 done, bit2 armed.
  - Every other address reads 0. `reg_rdata` follows `reg_addr` combinationally.
- R3: In trigger mode, an armed engine raises `cap_busy` at the third rising clock edge, counting from the first edge at which `trig_in` is sampled high.
- R4: In timer mode with delay P, `cap_busy` rises P+1 edges after the edge that writes the arm bit.
- R5: `in_ready` equals `cap_busy`. A word is accepted on each edge with `in_valid` and `in_ready` both high. Accepted words are written once each and in order.
- R6: A word accepted at edge k drives `sram_we_n` and `sram_ce_n` low for exactly the clock after edge k+1. During that clock, `sram_dq` holds that word and the address is stable.
- R7: The first word of a capture goes to address 0. Each following word goes to the previous address plus one.
- R8: A capture takes count+1 words. On the edge that accepts the last word, `cap_busy` falls and `cap_done` rises.
- R9: In wrap mode, the address continues from 2^AW-1 to 0 and the capture still takes count+1 words.
- R10: In stop mode, the capture ends after the word written to address 2^AW-1, even if the count is not used up.
- R11: Register writes while busy are ignored. `cap_done` stays set until a write to one of the addresses 0x00 to 0x04. Writes to any other address leave it set.
- R12: A trigger edge has no effect while the engine is disarmed. Arming while `trig_in` is already high does not start a capture until a new rising edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte |
| trig_in | input | 1 | External start trigger |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream ready, high while capturing |
| in_data | input | DW | Stream word |
| sram_addr | output | AW | RAM address |
| sram_dq | output | DW | RAM write data |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_ce_n | output | 1 | RAM chip select, active low |
| cap_busy | output | 1 | Capture running |
| cap_done | output | 1 | Capture finished |

## Verification
The stream is driven in two ways. An unbroken valid stream shows that the block sustains one write per clock with consecutive addresses. A stream with pseudo-random gaps shows that idle cycles neither consume a count nor advance the address. Both start sources are exercised: trigger edges arriving while disarmed, a trigger held high across arming, and the timer with a non-zero delay each give a different start cycle. Long captures in wrap mode and in stop mode separate address roll-over from early termination at the top location.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  localparam int REG_AW = 5;
  localparam int CNT_W  = 16;
  localparam int PER_W  = 16;

  localparam logic [REG_AW-1:0] A_CTRL     = 5'd0;
  localparam logic [REG_AW-1:0] A_CNT_L    = 5'd1;
  localparam logic [REG_AW-1:0] A_PER_L    = A_CNT_L + 5'(CNT_W / 8);
  localparam logic [REG_AW-1:0] A_CFG_LAST = A_PER_L + 5'(PER_W / 8) - 5'd1;
  localparam logic [REG_AW-1:0] A_STAT     = 5'h10;

  typedef struct packed {
    logic             use_timer;
    logic             wrap;
    logic [CNT_W-1:0] count;
    logic [PER_W-1:0] period;
  } cap_cfg_t;
endpackage

// File: rtl/pcap_regs.sv
module pcap_regs
  import pcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              busy,
  input  logic              done,
  input  logic              armed,
  output cap_cfg_t          cfg,
  output logic              arm_pulse,
  output logic              cfg_touch
);
  localparam int NB_C = CNT_W / 8;
  localparam int NB_P = PER_W / 8;

  logic accept;
  assign accept    = we && !busy;
  assign cfg_touch = accept && (addr <= A_CFG_LAST);
  assign arm_pulse = accept && (addr == A_CTRL) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.use_timer <= 1'b0;
      cfg.wrap      <= 1'b0;
    end else if (accept && addr == A_CTRL) begin
      cfg.use_timer <= wdata[1];
      cfg.wrap      <= wdata[2];
    end
  end

  // byte lanes of the word count
  for (genvar b = 0; b < NB_C; b++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg.count[b*8 +: 8] <= 8'h00;
      else if (accept && addr == (A_CNT_L + 5'(b)))
        cfg.count[b*8 +: 8] <= wdata;
    end
  end

  // byte lanes of the start delay
  for (genvar b = 0; b < NB_P; b++) begin : g_per
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg.period[b*8 +: 8] <= 8'h00;
      else if (accept && addr == (A_PER_L + 5'(b)))
        cfg.period[b*8 +: 8] <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == A_CTRL) rdata = {5'b0, cfg.wrap, cfg.use_timer, armed};
    if (addr == A_STAT) rdata = {5'b0, armed, done, busy};
    for (int b = 0; b < NB_C; b++)
      if (addr == (A_CNT_L + 5'(b))) rdata = cfg.count[b*8 +: 8];
    for (int b = 0; b < NB_P; b++)
      if (addr == (A_PER_L + 5'(b))) rdata = cfg.period[b*8 +: 8];
  end
endmodule

// File: rtl/pcap_trig.sv
module pcap_trig #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic rise
);
  logic [STAGES-1:0] sync;
  logic              prev;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync <= '0;
      else        sync <= trig_in;
    end
  end else begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync <= '0;
      else        sync <= {sync[STAGES-2:0], trig_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sync[STAGES-1];
  end

  assign rise = sync[STAGES-1] && !prev;
endmodule

// File: rtl/pcap_ctrl.sv
module pcap_ctrl
  import pcap_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cap_cfg_t      cfg,
  input  logic          arm_pulse,
  input  logic          cfg_touch,
  input  logic          trig_rise,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          busy,
  output logic          done,
  output logic          armed,
  output logic          fr_v,
  output logic [AW-1:0] fr_a,
  output logic [DW-1:0] fr_d
);
  localparam logic [AW-1:0] ADDR_TOP = '1;

  logic [CNT_W-1:0] rem;
  logic [PER_W-1:0] tcnt;
  logic [AW-1:0]    ptr;
  logic             start, take, last;

  assign in_ready = busy;
  assign take     = busy && in_valid;
  assign start    = armed && !busy &&
                    (cfg.use_timer ? (tcnt == cfg.period) : trig_rise);
  assign last     = (rem == '0) || (!cfg.wrap && ptr == ADDR_TOP);

  // front register: every bit of the word lands in the same clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_v <= 1'b0;
      fr_a <= '0;
      fr_d <= '0;
    end else begin
      fr_v <= take;
      if (take) begin
        fr_a <= ptr;
        fr_d <= in_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      armed <= 1'b0;
      rem   <= '0;
      tcnt  <= '0;
      ptr   <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      armed <= 1'b0;
      rem   <= cfg.count;
      ptr   <= '0;
      tcnt  <= '0;
    end else begin
      if (take) begin
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          rem <= rem - 1'b1;
        end
        ptr <= ptr + 1'b1;
      end
      if (arm_pulse) begin
        armed <= 1'b1;
        tcnt  <= '0;
      end else if (armed && cfg.use_timer) begin
        tcnt <= tcnt + 1'b1;
      end
      if (cfg_touch) done <= 1'b0;
    end
  end
endmodule

// File: rtl/pcap_wrport.sv
module pcap_wrport #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fr_v,
  input  logic [AW-1:0] fr_a,
  input  logic [DW-1:0] fr_d,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq,
  output logic          sram_we_n,
  output logic          sram_ce_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_we_n <= 1'b1;
      sram_ce_n <= 1'b1;
      sram_addr <= '0;
      sram_dq   <= '0;
    end else begin
      sram_we_n <= !fr_v;
      sram_ce_n <= !fr_v;
      if (fr_v) begin
        sram_addr <= fr_a;
        sram_dq   <= fr_d;
      end
    end
  end
endmodule

// File: rtl/pcap_sram_top.sv
module pcap_sram_top
  import pcap_pkg::*;
#(
  parameter int DW          = 16,
  parameter int AW          = 10,
  parameter int TRIG_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              trig_in,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  output logic [AW-1:0]     sram_addr,
  output logic [DW-1:0]     sram_dq,
  output logic              sram_we_n,
  output logic              sram_ce_n,
  output logic              cap_busy,
  output logic              cap_done
);
  cap_cfg_t      cfg;
  logic          arm_pulse, cfg_touch, trig_rise, armed;
  logic          fr_v;
  logic [AW-1:0] fr_a;
  logic [DW-1:0] fr_d;

  pcap_regs u_regs (
    .clk, .rst_n, .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(cap_busy), .done(cap_done), .armed,
    .cfg, .arm_pulse, .cfg_touch
  );

  pcap_trig #(.STAGES(TRIG_STAGES)) u_trig (
    .clk, .rst_n, .trig_in, .rise(trig_rise)
  );

  pcap_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk, .rst_n, .cfg, .arm_pulse, .cfg_touch, .trig_rise,
    .in_valid, .in_data, .in_ready, .busy(cap_busy), .done(cap_done),
    .armed, .fr_v, .fr_a, .fr_d
  );

  pcap_wrport #(.DW(DW), .AW(AW)) u_wr (
    .clk, .rst_n, .fr_v, .fr_a, .fr_d,
    .sram_addr, .sram_dq, .sram_we_n, .sram_ce_n
  );
endmodule

// File: rtl/pcap_chk.sv
module pcap_chk
  import pcap_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              in_valid,
  input logic [DW-1:0]     in_data,
  input logic [AW-1:0]     sram_addr,
  input logic [DW-1:0]     sram_dq,
  input logic              sram_we_n,
  input logic              cap_busy,
  input logic              cap_done
);
  // R5
  wr_in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> ($past(cap_busy, 2) && $past(in_valid, 2)));

  // R6
  data_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_dq == $past(in_data, 2)));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && !$past(sram_we_n)) |-> (sram_addr == $past(sram_addr) + 1'b1));

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_busy && cap_done));

  // R8
  end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_busy) |-> cap_done);

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && !(reg_we && reg_addr <= A_CFG_LAST)) |=> cap_done);
endmodule

bind pcap_sram_top pcap_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .in_valid(in_valid), .in_data(in_data), .sram_addr(sram_addr),
  .sram_dq(sram_dq), .sram_we_n(sram_we_n), .cap_busy(cap_busy),
  .cap_done(cap_done)
);

// File: tb/pcap_sram_top_tb.sv
`timescale 1ns/1ps
module pcap_sram_top_tb;
  import pcap_pkg::*;
  localparam int DW = 16, AW = 10, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, reg_we, trig_in, in_valid;
  logic [4:0]    reg_addr;
  logic [7:0]    reg_wdata, reg_rdata;
  logic [DW-1:0] in_data, sram_dq;
  logic [AW-1:0] sram_addr;
  logic          in_ready, sram_we_n, sram_ce_n, cap_busy, cap_done;

  pcap_sram_top #(.DW(DW), .AW(AW)) u_dut (.*);

  int compared = 0, mismatched = 0;
  bit stream_on = 0, gap_mode = 0;
  int n_wr = 0, last_addr = -1, prev_addr = -1;
  bit saw_wrap = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  bit m_busy, m_done, m_armed, m_src, m_wrap, ts0, ts1, tp, p_v, e_we;
  int m_cnt, m_per, m_rem, m_ptr, m_tcnt, p_a, e_addr;
  logic [DW-1:0] p_d, e_dq;

  always @(posedge clk) begin : ref_model
    bit acc, rise, start, ob, last;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_armed = 0; m_src = 0; m_wrap = 0;
      ts0 = 0; ts1 = 0; tp = 0; p_v = 0; e_we = 0;
      m_cnt = 0; m_per = 0; m_rem = 0; m_ptr = 0; m_tcnt = 0;
      p_a = 0; e_addr = 0; p_d = '0; e_dq = '0;
    end else begin
      ob = m_busy;
      e_we = p_v;
      if (p_v) begin e_addr = p_a; e_dq = p_d; end
      acc = m_busy && in_valid;
      p_v = acc;
      if (acc) begin p_a = m_ptr; p_d = in_data; end
      rise = ts1 && !tp;
      start = m_armed && !m_busy && (m_src ? (m_tcnt == m_per) : rise);
      tp = ts1; ts1 = ts0; ts0 = trig_in;
      if (start) begin
        m_busy = 1; m_armed = 0; m_rem = m_cnt; m_ptr = 0; m_tcnt = 0;
      end else begin
        if (acc) begin
          last = (m_rem == 0) || (!m_wrap && m_ptr == DEPTH - 1);
          if (last) begin m_busy = 0; m_done = 1; end
          else m_rem--;
          m_ptr = (m_ptr + 1) % DEPTH;
        end
        if (m_armed && m_src) m_tcnt++;
        if (reg_we && !ob) begin
          case (reg_addr)
            5'd0: begin
              m_src = reg_wdata[1]; m_wrap = reg_wdata[2];
              if (reg_wdata[0]) begin m_armed = 1; m_tcnt = 0; end
            end
            5'd1: m_cnt = (m_cnt & 'hFF00) | reg_wdata;
            5'd2: m_cnt = (m_cnt & 'h00FF) | (int'(reg_wdata) << 8);
            5'd3: m_per = (m_per & 'hFF00) | reg_wdata;
            5'd4: m_per = (m_per & 'h00FF) | (int'(reg_wdata) << 8);
            default: ;
          endcase
          if (reg_addr <= 5'd4) m_done = 0;
        end
      end
    end
  end

  // per-clock comparison, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(sram_we_n == !e_we, "R6 we_n", sram_we_n, !e_we);
      chk(sram_ce_n == !e_we, "R6 ce_n", sram_ce_n, !e_we);
      if (e_we) begin
        chk(sram_addr == AW'(e_addr), "R7 addr", sram_addr, e_addr);
        chk(sram_dq == e_dq, "R6 data", sram_dq, e_dq);
      end
      chk(in_ready == m_busy, "R5 in_ready", in_ready, m_busy);
      chk(cap_busy == m_busy, "R8 busy", cap_busy, m_busy);
      chk(cap_done == m_done, "R11 done", cap_done, m_done);
      if (reg_addr == A_STAT && !reg_we)
        chk(reg_rdata == {5'b0, m_armed, m_done, m_busy}, "R2 status",
            reg_rdata, {5'b0, m_armed, m_done, m_busy});
      if (!sram_we_n) begin
        n_wr++;
        if (prev_addr == DEPTH - 1 && sram_addr == 0) saw_wrap = 1;
        prev_addr = sram_addr;
        last_addr = sram_addr;
      end
    end
  end

  // stream source
  initial begin : src
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    in_valid = 0;
    in_data = '0;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid = stream_on && (!gap_mode || lfsr[0] || lfsr[5]);
      in_data = DW'(in_data + 16'h1357);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 0; reg_addr = A_STAT;
  endtask

  task automatic reg_rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata == exp, tag, reg_rdata, exp);
    tick(1);
    reg_addr = A_STAT;
  endtask

  task automatic setup(input int cnt, input int per, input logic [7:0] ctrl);
    n_wr = 0; last_addr = -1; prev_addr = -1; saw_wrap = 0;
    reg_wr(5'd1, cnt[7:0]);
    reg_wr(5'd2, cnt[15:8]);
    reg_wr(5'd3, per[7:0]);
    reg_wr(5'd4, per[15:8]);
    reg_wr(5'd0, ctrl);
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (!cap_done && k < 5000) begin @(negedge clk); k++; end
    chk(cap_done, tag, cap_done, 1);
    repeat (3) @(negedge clk);
    tick(1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL R8 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    int n;
    rst_n = 0; reg_we = 0; reg_addr = A_STAT; reg_wdata = 0; trig_in = 0;
    tick(4);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    chk(sram_we_n && sram_ce_n, "R1 strobes", {sram_we_n, sram_ce_n}, 3);
    chk(!in_ready && !cap_busy && !cap_done, "R1 flags", {in_ready, cap_busy, cap_done}, 0);
    chk(reg_rdata == 8'h00, "R1 status", reg_rdata, 0);
    tick(1);
    stream_on = 1;

    // trigger start, unbroken stream, count 7
    setup(7, 16'h0102, 8'h01);
    reg_rd(5'd1, 8'h07, "R2 count lo");
    reg_rd(5'd2, 8'h00, "R2 count hi");
    reg_rd(5'd3, 8'h02, "R2 delay lo");
    reg_rd(5'd4, 8'h01, "R2 delay hi");
    reg_rd(5'd0, 8'h01, "R2 control");
    reg_rd(5'h1F, 8'h00, "R2 unused");
    trig_in = 1;
    n = 0;
    do begin tick(1); n++; end while (!cap_busy && n < 20);
    chk(n == 3, "R3 trigger latency", n, 3);
    trig_in = 0;
    wait_done("R8 done trig");
    chk(n_wr == 8, "R8 word count", n_wr, 8);
    chk(last_addr == 7, "R7 last address", last_addr, 7);

    // disarmed trigger and trigger held across arming
    n_wr = 0;
    trig_in = 1; tick(3); trig_in = 0; tick(10);
    chk(!cap_busy && n_wr == 0, "R12 disarmed edge", {cap_busy, 8'(n_wr)}, 0);
    chk(cap_done, "R11 done held", cap_done, 1);
    trig_in = 1; tick(4);
    setup(7, 0, 8'h01);
    tick(10);
    chk(!cap_busy, "R12 held trigger", cap_busy, 0);
    reg_rd(A_STAT, 8'h04, "R12 still armed");
    trig_in = 0; tick(3); trig_in = 1;
    wait_done("R12 new edge");
    trig_in = 0;
    chk(n_wr == 8, "R12 capture after edge", n_wr, 8);

    // timer start, gapped stream, write attempt while busy
    gap_mode = 1;
    setup(20, 5, 8'h03);
    n = 0;
    do begin tick(1); n++; end while (!cap_busy && n < 50);
    chk(n == 6, "R4 timer latency", n, 6);
    reg_wr(5'd1, 8'hAA);
    wait_done("R8 done timer");
    chk(n_wr == 21, "R8 gapped count", n_wr, 21);
    reg_rd(5'd1, 8'h14, "R11 busy write ignored");
    reg_wr(5'h08, 8'h00);
    @(negedge clk);
    chk(cap_done, "R11 other address keeps done", cap_done, 1);
    tick(1);
    reg_wr(5'd4, 8'h00);
    @(negedge clk);
    chk(!cap_done, "R11 config write clears done", cap_done, 0);
    tick(1);

    // wrap mode past the top
    gap_mode = 0;
    setup(1100, 0, 8'h07);
    wait_done("R9 done wrap");
    chk(n_wr == 1101, "R9 wrap count", n_wr, 1101);
    chk(saw_wrap, "R9 roll-over", saw_wrap, 1);
    chk(last_addr == 76, "R9 last address", last_addr, 76);

    // stop mode ends at the top
    setup(1100, 0, 8'h03);
    wait_done("R10 done stop");
    chk(n_wr == DEPTH, "R10 stop count", n_wr, DEPTH);
    chk(last_addr == DEPTH - 1, "R10 last address", last_addr, DEPTH - 1);

    tick(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule